// File: doc/BRIEF.md
# Streaming CRC-16 Group Checker

This block checks a data group for transmission errors while the bytes arrive. A host writes the payload bytes of a group one at a time into a data port and then writes the group's 16-bit check word as two more bytes, high byte first. Every accepted byte advances a 16-bit CRC residue by one step. The generator is x^16 + x^12 + x^5 + 1 and each byte is fed in most significant bit first. When the residue is all zeros, the group is error-free, and the block shows this on a pass pin and on a pass bit in a small status word.

The host clears the residue with a control bit that is held by level. The block never releases that bit. While it stays high, the residue is held at zero and byte writes are dropped, so the host must lower it before it sends data. A group that passes leaves the residue at zero, so the host can start the next group at once without clearing. The block does not frame groups and does not count bytes. It places no limit on how many bytes a group may contain.

Top module: `crc16_group_chk`

## Requirements
- R1: During and right after the synchronous active-high `rst`, `residue_o` is 16'h0000 and `pass_o` is 1.
- R2: A write (`wr_en`=1) while `clr_hold`=0 replaces the residue at the next clock edge. The new value comes from eight MSB-first steps of `wr_data`. One step is: feedback = residue[15] XOR data bit; residue = (residue << 1) XOR (feedback ? 16'h1021 : 0).
- R3: When `wr_en`=0 and `clr_hold`=0, the residue keeps its value.
- R4: `pass_o` is 1 exactly when all 16 residue bits are 0, in the same cycle as that residue value.
- R5: `status_o` is 8 bits wide. Bit 1 equals `pass_o` and every other bit is 0.
- R6: While `clr_hold`=1, the residue is 0 from the next edge onward and writes have no effect. It stays 0 until writes resume after `clr_hold` returns to 0.
- R7: Suppose a group starts from residue R and its check word is the CRC that the payload gives from R, written high byte first. After the check word the residue is 0, so the next group can start without a clear.
- R8: If any single bit of a group or its check word is flipped, the final residue is nonzero and `pass_o` is 0.
- R9: The residue keeps accumulating with no length limit. A group of 1000 payload bytes with its check word ends at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| clr_hold | input | 1 | Level-held residue clear; writes are dropped while high |
| wr_en | input | 1 | Byte write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to fold into the residue |
| residue_o | output | 16 | Current CRC residue |
| pass_o | output | 1 | High when the residue is zero |
| status_o | output | 8 | Status word, pass flag at bit 1 |

## Verification
The hardest case to reach is the zero residue after a long run of random traffic. It only appears when the bench sends the exact check word that the preceding bytes produced, and it has to occur again on the following group with no clear in between. The stimulus therefore computes each group's check word from the bench's own residue model and appends it. It then chains several groups back to back, including a 1000-byte group. It also replays groups with one flipped bit at random positions, including positions inside the check word. Writes issued while the clear is held check that dropped bytes leave no trace.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int CRC_W   = 16;
    localparam int BYTE_W  = 8;
    localparam logic [CRC_W-1:0] GEN_POLY = 16'h1021;
    localparam int STAT_W  = 8;
    localparam int PASS_POS = 1;

    typedef struct packed {
        logic [CRC_W-1:0] residue;
    } chk_state_t;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
    parameter int W = 16,
    parameter int DW = 8,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic [W-1:0]  crc_in,
    input  logic [DW-1:0] byte_in,
    output logic [W-1:0]  crc_out
);
    logic [W-1:0] stage [0:DW];

    assign stage[0] = crc_in;

    for (genvar k = 0; k < DW; k++) begin : g_bit
        logic fb;
        assign fb = stage[k][W-1] ^ byte_in[DW-1-k];
        assign stage[k+1] = {stage[k][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DW];
endmodule

// File: rtl/crc16_zero_flag.sv
module crc16_zero_flag #(
    parameter int W = 16,
    parameter int SW = 8,
    parameter int FLAG_POS = 1
) (
    input  logic [W-1:0]  vec,
    output logic          is_zero,
    output logic [SW-1:0] stat
);
    always_comb begin
        is_zero = ~|vec;
        stat = '0;
        stat[FLAG_POS] = is_zero;
    end
endmodule

// File: rtl/crc16_group_chk.sv
module crc16_group_chk
    import crc16_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_hold,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [CRC_W-1:0]    residue_o,
    output logic                pass_o,
    output logic [STAT_W-1:0]   status_o
);
    chk_state_t state_d, state_q;
    logic [CRC_W-1:0] stepped;

    crc16_byte_step #(
        .W(CRC_W), .DW(BYTE_W), .POLY(GEN_POLY)
    ) i_step (
        .crc_in(state_q.residue),
        .byte_in(wr_data),
        .crc_out(stepped)
    );

    crc16_zero_flag #(
        .W(CRC_W), .SW(STAT_W), .FLAG_POS(PASS_POS)
    ) i_zero (
        .vec(state_q.residue),
        .is_zero(pass_o),
        .stat(status_o)
    );

    always_comb begin
        state_d = state_q;
        if (clr_hold) begin
            state_d.residue = '0;
        end else if (wr_en) begin
            state_d.residue = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign residue_o = state_q.residue;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !clr_hold) |=> $stable(residue_o)); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_hold |=> (residue_o == '0)); // R6
    AST_CLR_PASS: assert property (@(posedge clk) disable iff (rst)
        clr_hold |=> pass_o); // R4
    AST_WR_LEAVES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_hold && pass_o && wr_data != '0) |=> !pass_o); // R2
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ($countones(status_o) == (pass_o ? 1 : 0)) && (status_o[PASS_POS] == pass_o)); // R5
endmodule

// File: tb/test_crc16_group_chk.sv
`timescale 1ns/1ps
module test_crc16_group_chk;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_hold = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [15:0] residue_o;
    logic pass_o;
    logic [7:0] status_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] model = 16'h0000;

    always #5 clk = ~clk;

    crc16_group_chk i_crc16_group_chk (
        .clk(clk), .rst(rst), .clr_hold(clr_hold), .wr_en(wr_en),
        .wr_data(wr_data), .residue_o(residue_o), .pass_o(pass_o),
        .status_o(status_o)
    );

    function automatic logic [15:0] ref_byte(input logic [15:0] r, input logic [7:0] b);
        int acc = r;
        for (int i = 7; i >= 0; i--) begin
            int top = (acc >> 15) & 1;
            int din = (b >> i) & 1;
            acc = (acc << 1) & 16'hFFFF;
            if ((top ^ din) == 1) acc = acc ^ 16'h1021;
        end
        return acc[15:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst || clr_hold) model = 16'h0000;
        else if (wr_en) model = ref_byte(model, wr_data);
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(residue_o == model, "R2 residue", {16'h0, residue_o}, {16'h0, model});
            check(pass_o == (model == 16'h0), "R4 pass", {31'h0, pass_o}, {31'h0, model == 16'h0});
            check(status_o == {6'b0, model == 16'h0, 1'b0}, "R5 status", {24'h0, status_o},
                  {24'h0, 6'b0, model == 16'h0, 1'b0});
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Sends a group; flip_bit < 0 means no error, else flips that bit index of group+check.
    task automatic send_group(input int len, input int flip_bit, output logic [15:0] final_res);
        logic [7:0] bytes [$];
        logic [15:0] r = model;
        for (int i = 0; i < len; i++) bytes.push_back(8'($urandom));
        foreach (bytes[i]) r = ref_byte(r, bytes[i]);
        bytes.push_back(r[15:8]);
        bytes.push_back(r[7:0]);
        if (flip_bit >= 0) bytes[flip_bit/8][7 - flip_bit%8] ^= 1'b1;
        @(negedge clk);
        foreach (bytes[i]) begin
            wr_en = 1'b1;
            wr_data = bytes[i];
            @(negedge clk);
        end
        wr_en = 1'b0;
        final_res = residue_o;
    endtask

    initial begin
        logic [15:0] res;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        check(residue_o == 16'h0, "R1 reset residue", {16'h0, residue_o}, 32'h0);
        check(pass_o == 1'b1, "R1 reset pass", {31'h0, pass_o}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check(residue_o == 16'h0 && pass_o, "R1 after reset", {16'h0, residue_o}, 32'h0);

        put(8'h01);
        check(residue_o == 16'h1021, "R2 single byte 01", {16'h0, residue_o}, 32'h1021);
        put(8'h80);
        check(residue_o == ref_byte(16'h1021, 8'h80), "R2 second byte", {16'h0, residue_o},
              {16'h0, ref_byte(16'h1021, 8'h80)});

        held = residue_o;
        idle(5);
        check(residue_o == held && !pass_o, "R3 idle hold", {16'h0, residue_o}, {16'h0, held});

        @(negedge clk); clr_hold = 1'b1;
        @(negedge clk);
        check(residue_o == 16'h0 && pass_o, "R6 clear", {16'h0, residue_o}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_data = 8'hA5 + 8'(i);
            @(negedge clk);
            check(residue_o == 16'h0, "R6 write ignored", {16'h0, residue_o}, 32'h0);
        end
        wr_en = 1'b0;
        clr_hold = 1'b0;
        idle(2);
        check(residue_o == 16'h0, "R6 stays zero after release", {16'h0, residue_o}, 32'h0);

        for (int g = 0; g < 6; g++) begin
            send_group(1 + g * 7, -1, res);
            check(res == 16'h0 && pass_o, "R7 chained group zero", {16'h0, res}, 32'h0);
        end

        put(8'h3C);
        put(8'hC3);
        send_group(10, -1, res);
        check(res == 16'h0, "R7 from nonzero start", {16'h0, res}, 32'h0);

        for (int t = 0; t < 40; t++) begin
            int len = 1 + ($urandom % 20);
            int pos = $urandom % ((len + 2) * 8);
            @(negedge clk); clr_hold = 1'b1;
            @(negedge clk); clr_hold = 1'b0;
            send_group(len, pos, res);
            check(res != 16'h0 && !pass_o, "R8 single-bit error detected", {16'h0, res}, 32'h1);
        end
        for (int p = 0; p < 16; p++) begin
            @(negedge clk); clr_hold = 1'b1;
            @(negedge clk); clr_hold = 1'b0;
            send_group(3, 24 + p, res);
            check(res != 16'h0, "R8 error in check word", {16'h0, res}, 32'h1);
        end

        @(negedge clk); clr_hold = 1'b1;
        @(negedge clk); clr_hold = 1'b0;
        send_group(1000, -1, res);
        check(res == 16'h0 && pass_o, "R9 long group", {16'h0, res}, 32'h0);
        send_group(5, -1, res);
        check(res == 16'h0, "R9 after long group", {16'h0, res}, 32'h0);

        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule